// File: doc/BRIEF.md
# Serial Digit Readout with Shared Status Pin

This block hands a 4-bit decoded digit to an external controller over a single output pin. The controller clocks the bits out by toggling an acknowledge input. The same pin carries an energy-present level whenever no transfer is in progress. A steering flag from the upstream digit detector marks when a fresh code is valid.

The block's controller is a four-state machine:

- `ST_ARMED` waits for the first acknowledge rise while steering is high.
- `ST_SHIFT` drives latched bits, least significant first.
- `ST_DONE` ignores all acknowledge activity until the next steering rise.
- `ST_SLEEP` is the powerdown state.

The state machine has these transitions:

- ARMED→SHIFT on the first qualified acknowledge rise.
- SHIFT→DONE on the falling edge of the fourth pulse.
- DONE→ARMED on a steering rise.
- Any state→SLEEP on a powerdown rise while acknowledge is low.
- SLEEP→ARMED when powerdown drops.

The acknowledge and powerdown inputs each pass through a two-flop synchroniser before their edges are detected.

Top module: `serdig_readout`

## Requirements
- R1: After reset the block is armed and the pin shows `energy_i`.
- R2: In the armed state, a rising edge of the acknowledge input while `steer_i` is high latches `code_i` and drives bit 0 of the latched code on the pin.
- R3: Each of the next three acknowledge rises drives the next latched bit (bit 1, then bit 2, then bit 3). Between rises the pin holds its bit, and changes on `code_i` or `energy_i` have no effect on it.
- R4: From the falling edge of the fourth acknowledge pulse on, the pin shows `energy_i` again.
- R5: While a transfer has fewer than four pulses, no new code is latched, even if steering falls and rises again. The pulses that follow continue shifting the old code.
- R6: After a complete transfer, further acknowledge pulses are ignored and the pin keeps showing `energy_i`. Only a rising edge of `steer_i` re-arms the block, after which a new four-pulse transfer works.
- R7: In the armed state, an acknowledge rise while `steer_i` is low is ignored and the pin keeps showing `energy_i`.
- R8: A rise of the synchronised powerdown input while acknowledge is low forces the pin low, regardless of `energy_i`, until powerdown falls. This aborts any transfer in progress. The block then returns to the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| steer_i | input | 1 | Digit-valid steering flag (synchronous) |
| code_i | input | 4 | Decoded digit code |
| energy_i | input | 1 | Energy-present level |
| ack_i | input | 1 | Acknowledge pulse train, idles low (asynchronous) |
| pwdn_i | input | 1 | Powerdown request (asynchronous) |
| sdo_o | output | 1 | Shared serial data / energy status pin |

## Verification
The bench targets three cases:

- **Short burst.** It stops after two pulses, then gives steering a fresh rise with a different code. A design that relatched here would emit the new code's bits instead of finishing the old one.
- **Surplus pulses.** It sends pulses after the fourth. A design without a lockout would start a new transfer and put data on the pin where energy status belongs.
- **Guard conditions.** It checks a pulse with steering low, which must not start a transfer. It checks energy toggling mid-window, which must not leak onto the pin. It checks powerdown, which must hold the pin low even with energy present, and a design that wrongly recovered from it would fail to run a clean transfer afterwards.

// File: rtl/serdig_pkg.sv
package serdig_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2,
        ST_SLEEP = 2'd3
    } rd_state_t;
endpackage

// File: rtl/serdig_sync.sv
module serdig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/serdig_edge.sv
module serdig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= d;
    end

    assign rise = d & ~prev;
    assign fall = ~d & prev;
endmodule

// File: rtl/serdig_readout.sv
module serdig_readout
    import serdig_pkg::*;
#(
    parameter int CODE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              steer_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              energy_i,
    input  logic              ack_i,
    input  logic              pwdn_i,
    output logic              sdo_o
);
    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_W);

    logic ack_s, pwdn_s;
    logic ack_rise, ack_fall, pwdn_rise, pwdn_fall_unused;
    logic steer_rise, steer_fall_unused;

    serdig_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d(ack_i), .q(ack_s));
    serdig_sync #(.STAGES(SYNC_STAGES)) u_sync_pwdn (
        .clk(clk), .rst_n(rst_n), .d(pwdn_i), .q(pwdn_s));

    serdig_edge u_edge_ack (
        .clk(clk), .rst_n(rst_n), .d(ack_s), .rise(ack_rise), .fall(ack_fall));
    serdig_edge u_edge_pwdn (
        .clk(clk), .rst_n(rst_n), .d(pwdn_s), .rise(pwdn_rise), .fall(pwdn_fall_unused));
    serdig_edge u_edge_steer (
        .clk(clk), .rst_n(rst_n), .d(steer_i), .rise(steer_rise), .fall(steer_fall_unused));

    rd_state_t         state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [CODE_W-1:0] shreg, shreg_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            shreg <= shreg_nx;
        end
    end

    // Transition logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        shreg_nx = shreg;
        if (pwdn_rise && !ack_s) begin
            state_nx = ST_SLEEP;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_ARMED: begin
                    if (ack_rise && steer_i) begin
                        shreg_nx = code_i;
                        cnt_nx   = CNT_W'(1);
                        state_nx = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (ack_rise && cnt < CNT_FULL) begin
                        shreg_nx = shreg >> 1;
                        cnt_nx   = cnt + CNT_W'(1);
                    end else if (ack_fall && cnt == CNT_FULL) begin
                        state_nx = ST_DONE;
                    end
                end
                ST_DONE: begin
                    if (steer_rise) begin
                        state_nx = ST_ARMED;
                        cnt_nx   = '0;
                    end
                end
                ST_SLEEP: begin
                    if (!pwdn_s) begin
                        state_nx = ST_ARMED;
                        cnt_nx   = '0;
                    end
                end
                default: state_nx = ST_ARMED;
            endcase
        end
    end

    // Output logic
    always_comb begin
        unique case (state)
            ST_SHIFT: sdo_o = shreg[0];
            ST_SLEEP: sdo_o = 1'b0;
            default:  sdo_o = energy_i;
        endcase
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL); // R3

    AST_ENTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) != ST_SHIFT)
        |-> ($past(state) == ST_ARMED && $past(steer_i))); // R2

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) == ST_SHIFT && !$past(ack_rise))
        |-> $stable(sdo_o)); // R3

    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_SHIFT) |-> cnt == CNT_FULL); // R4

    AST_REARM_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $past(state) == ST_DONE) |-> $past(steer_rise)); // R6

    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) != ST_SLEEP) |-> $past(pwdn_rise)); // R8
endmodule

// File: tb/serdig_readout_tb.sv
module serdig_readout_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       steer_i = 1'b0;
    logic [3:0] code_i = 4'h0;
    logic       energy_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       pwdn_i = 1'b0;
    logic       sdo_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    serdig_readout u_dut (
        .clk(clk), .rst_n(rst_n), .steer_i(steer_i), .code_i(code_i),
        .energy_i(energy_i), .ack_i(ack_i), .pwdn_i(pwdn_i), .sdo_o(sdo_o));

    always #10 clk = ~clk;

    // {energy, code}
    localparam logic [4:0] VEC [6] = '{
        5'b0_0001, 5'b1_1010, 5'b0_1111, 5'b1_0000, 5'b0_0110, 5'b1_1101
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp);
        checks++;
        if (sdo_o !== exp) begin
            errors++;
            $display("FAIL %s: sdo=%b expected %b", req, sdo_o, exp);
        end
    endtask

    // one acknowledge pulse; check pin while high and after fall
    task automatic pulse(input string req, input logic exp_hi, input logic exp_lo);
        ack_i = 1'b1; tick(4);
        chk(req, exp_hi);
        ack_i = 1'b0; tick(4);
        chk(req, exp_lo);
    endtask

    task automatic steer_up(input logic [3:0] code);
        steer_i = 1'b0; tick(2);
        code_i = code; steer_i = 1'b1; tick(2);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        energy_i = 1'b1;
        tick(3);
        chk("R1 reset", 1'b1);
        rst_n = 1'b1; tick(2);
        energy_i = 1'b0; tick(1);
        chk("R1 idle", 1'b0);

        // Table-driven full transfers
        for (int v = 0; v < 6; v++) begin
            logic [3:0] c;
            logic e;
            c = VEC[v][3:0];
            e = VEC[v][4];
            energy_i = e;
            steer_up(c);
            chk("R4 idle before", e);
            pulse("R2 bit0", c[0], c[0]);
            code_i = ~c;
            pulse("R3 bit1", c[1], c[1]);
            energy_i = ~e; tick(1);
            chk("R3 energy ignored", c[1]);
            pulse("R3 bit2", c[2], c[2]);
            ack_i = 1'b1; tick(4);
            chk("R3 bit3", c[3]);
            ack_i = 1'b0; tick(4);
            chk("R4 energy after", ~e);
        end

        // Short burst lockout
        energy_i = 1'b1;
        steer_up(4'b0110);
        pulse("R5 A bit0", 1'b0, 1'b0);
        pulse("R5 A bit1", 1'b1, 1'b1);
        steer_up(4'b1001);
        pulse("R5 A bit2 continues", 1'b1, 1'b1);
        ack_i = 1'b1; tick(4);
        chk("R5 A bit3 continues", 1'b0);
        ack_i = 1'b0; tick(4);
        chk("R5 done energy", 1'b1);

        // Surplus pulses ignored
        energy_i = 1'b0;
        pulse("R6 surplus", 1'b0, 1'b0);
        energy_i = 1'b1;
        pulse("R6 surplus e1", 1'b1, 1'b1);
        steer_up(4'b1001);
        pulse("R6 rearm bit0", 1'b1, 1'b1);
        pulse("R6 rearm bit1", 1'b0, 1'b0);
        pulse("R6 rearm bit2", 1'b0, 1'b0);
        pulse("R6 rearm bit3", 1'b1, 1'b1);

        // Pulse with steering low in armed state
        steer_up(4'b0011);
        steer_i = 1'b0; tick(2);
        energy_i = 1'b0;
        pulse("R7 steer low", 1'b0, 1'b0);
        steer_i = 1'b1; tick(2);
        pulse("R7 then bit0", 1'b1, 1'b1);

        // Powerdown mid-transfer
        energy_i = 1'b1;
        pwdn_i = 1'b1; tick(5);
        chk("R8 pin low", 1'b0);
        pulse("R8 ack in sleep", 1'b0, 1'b0);
        pwdn_i = 1'b0; tick(5);
        chk("R8 exit energy", 1'b1);
        steer_i = 1'b1; code_i = 4'b1100; tick(2);
        pulse("R8 after bit0", 1'b0, 1'b0);
        pulse("R8 after bit1", 1'b0, 1'b0);
        pulse("R8 after bit2", 1'b1, 1'b1);
        pulse("R8 after bit3", 1'b1, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule